// File: doc/BRIEF.md
# Four-Channel Suppressible PWM Generator

This block drives four pulse-width outputs from one 10-bit period counter that advances once per prescaler tick, so every channel runs at the same frequency (1024 ticks per period). Each channel holds its own 10-bit duty value and a mode. In contiguous mode the channel makes one pulse at the start of the period. In spread mode the period is cut into four quarters of 256 counts, and the high time is shared out among them. Each channel can also blank its output in whole periods at a fixed ratio. An end-of-period interrupt pulse can be enabled, and it can be thinned with the same ratios.

Software sets the block up through a plain write strobe with an address and a data word. Writes are always accepted in the cycle they are presented. There is no back-pressure and no ready signal. Every written value goes into a shadow register, and the shadow is copied into the working register at the period boundary. This means a change never cuts a pulse short or adds a stray one. A global period index counts completed periods from reset. The suppression ratios use this index to choose which periods are kept.

Top module: `pwm_quad`

## Requirements
- R1: The shared counter advances by one only in clocks where `tick` is high. It wraps from 1023 to 0, so a period is 1024 ticks. While `tick` is low, every output holds its value.
- R2: In contiguous mode (spread bit 0), a channel is high at counts 0 through duty-1 of each period it keeps, and low otherwise.
- R3: In spread mode (spread bit 1), quarter q = count[9:8] and position p = count[7:0]. The output is high when p < duty[9:2] + (q < duty[1:0] ? 1 : 0). The total high time per kept period therefore equals the duty.
- R4: A duty of 0 keeps the output low for the whole period in both modes.
- R5: The suppression code works against the period index i (a 3-bit count of completed periods since reset, starting at 0). Code 0 keeps every period. Code 1 keeps periods with i mod 2 = 0. Code 2 keeps periods with i mod 4 = 0. Code 3 keeps periods with i mod 8 = 0. In a suppressed period the output stays low.
- R6: When enabled, `irq_o` is high for exactly one clock: the clock after the tick that ends a period. The interrupt suppression code keeps it, using the same rule as R5, only when the index of the ending period passes that rule. The enable and code in force for the ending period decide.
- R7: Writes land in shadow registers and take effect at the first count of the next period. A write in the middle of a period does not change the current period's output.
- R8: Register map. Addresses 0 to 3 select channels 0 to 3, with data[9:0] = duty, data[10] = spread, and data[12:11] = suppression code. Address 4 sets the interrupt, with data[0] = enable and data[2:1] = suppression code. Writes to addresses 5 to 7 are ignored.
- R9: After reset the counter and period index are 0, all settings are 0, and every output is low until new settings take effect.
- R10: A write to one channel leaves the other channels' outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaler enable; the counter advances on clocks where it is high |
| wr_en | input | 1 | Register write strobe, always accepted |
| wr_addr | input | 3 | Register address |
| wr_data | input | 13 | Register write data |
| pwm_o | output | 4 | PWM outputs, bit n is channel n |
| irq_o | output | 1 | End-of-period interrupt pulse |

## Verification
If the counter or period index is corrupted, the pulse edges move and the blanked periods change on the very next tick. The bench catches this by comparing every output against its own model at every clock. If a working register loads at the wrong time, the old duty appears after a write, or the new duty appears inside the current period; in either case the mismatch shows within one period. A fault in the interrupt gating or in the suppression phase only shows over a full eight-period window. For that reason, the total high counts and the interrupt counts are checked over eight periods for each table entry.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;

  // Period index width: the longest suppression ratio spans 8 periods.
  localparam int IDX_W = 3;

  typedef enum logic [1:0] {
    SUP_NONE = 2'd0,
    SUP_1OF2 = 2'd1,
    SUP_3OF4 = 2'd2,
    SUP_7OF8 = 2'd3
  } sup_e;

  // True when the period with index idx is kept under ratio s.
  function automatic logic sup_pass(sup_e s, logic [IDX_W-1:0] idx);
    logic keep;
    case (s)
      SUP_NONE: keep = 1'b1;
      SUP_1OF2: keep = (idx[0] == 1'b0);
      SUP_3OF4: keep = (idx[1:0] == 2'b00);
      default:  keep = (idx == '0);
    endcase
    return keep;
  endfunction

endpackage

// File: rtl/pwm_quad_timebase.sv
module pwm_quad_timebase
  import pwm_quad_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [IDX_W-1:0] cyc_o,
  output logic             wrap_o
);

  localparam logic [CNT_W-1:0] CNT_LAST = '1;

  assign wrap_o = tick_i && (cnt_o == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o <= '0;
      cyc_o <= '0;
    end else if (tick_i) begin
      cnt_o <= cnt_o + 1'b1;
      if (cnt_o == CNT_LAST) cyc_o <= cyc_o + 1'b1;
    end
  end

  // R1
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_o) && $stable(cyc_o));

  // R1
  cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && cnt_o == CNT_LAST) |=> (cnt_o == '0) && (cyc_o == IDX_W'($past(cyc_o) + 1'b1)));

endmodule

// File: rtl/pwm_quad_chan.sv
module pwm_quad_chan
  import pwm_quad_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int SPLIT_LG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             spread_i,
  input  sup_e             sup_i,
  input  logic             wrap_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [IDX_W-1:0] cyc_i,
  output logic             pwm_o
);

  localparam int POS_W  = CNT_W - SPLIT_LG;
  localparam int BASE_W = CNT_W - SPLIT_LG;

  logic [CNT_W-1:0] sh_duty, act_duty;
  logic             sh_spread, act_spread;
  sup_e             sh_sup, act_sup;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_duty    <= '0;
      sh_spread  <= 1'b0;
      sh_sup     <= SUP_NONE;
      act_duty   <= '0;
      act_spread <= 1'b0;
      act_sup    <= SUP_NONE;
    end else begin
      if (wr_i) begin
        sh_duty   <= duty_i;
        sh_spread <= spread_i;
        sh_sup    <= sup_i;
      end
      if (wrap_i) begin
        act_duty   <= sh_duty;
        act_spread <= sh_spread;
        act_sup    <= sh_sup;
      end
    end
  end

  logic [SPLIT_LG-1:0] quarter;
  logic [POS_W-1:0]    pos;
  logic [BASE_W-1:0]   base;
  logic [SPLIT_LG-1:0] extra;
  logic [POS_W:0]      slot_w;
  logic                lvl_single, lvl_spread, keep;

  always_comb begin
    quarter    = cnt_i[CNT_W-1 -: SPLIT_LG];
    pos        = cnt_i[POS_W-1:0];
    base       = act_duty[CNT_W-1:SPLIT_LG];
    extra      = act_duty[SPLIT_LG-1:0];
    slot_w     = {1'b0, base} + (POS_W+1)'(quarter < extra);
    lvl_single = (cnt_i < act_duty);
    lvl_spread = ({1'b0, pos} < slot_w);
    keep       = sup_pass(act_sup, cyc_i);
    pwm_o      = keep && (act_spread ? lvl_spread : lvl_single);
  end

  // R7
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_i |=> $stable(act_duty) && $stable(act_spread) && $stable(act_sup));

  // R4
  zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_duty == '0) |-> !pwm_o);

endmodule

// File: rtl/pwm_quad_irq.sv
module pwm_quad_irq
  import pwm_quad_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic             en_i,
  input  sup_e             sup_i,
  input  logic             wrap_i,
  input  logic [IDX_W-1:0] cyc_i,
  output logic             irq_o
);

  logic sh_en, act_en;
  sup_e sh_sup, act_sup;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_en   <= 1'b0;
      sh_sup  <= SUP_NONE;
      act_en  <= 1'b0;
      act_sup <= SUP_NONE;
      irq_o   <= 1'b0;
    end else begin
      if (wr_i) begin
        sh_en  <= en_i;
        sh_sup <= sup_i;
      end
      if (wrap_i) begin
        act_en  <= sh_en;
        act_sup <= sh_sup;
      end
      irq_o <= wrap_i && act_en && sup_pass(act_sup, cyc_i);
    end
  end

  // R6
  irq_after_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(wrap_i));

  // R6
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
  import pwm_quad_pkg::*;
#(
  parameter  int NCH    = 4,
  parameter  int CNT_W  = 10,
  parameter  int ADDR_W = 3,
  localparam int DATA_W = CNT_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NCH-1:0]    pwm_o,
  output logic              irq_o
);

  localparam int SPR_BIT = CNT_W;
  localparam int SUP_LSB = CNT_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] cyc;
  logic             wrap;

  pwm_quad_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick),
    .cnt_o  (cnt),
    .cyc_o  (cyc),
    .wrap_o (wrap)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic sel;
    assign sel = wr_en && (wr_addr == ADDR_W'(i));

    pwm_quad_chan #(.CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (sel),
      .duty_i   (wr_data[CNT_W-1:0]),
      .spread_i (wr_data[SPR_BIT]),
      .sup_i    (sup_e'(wr_data[SUP_LSB +: 2])),
      .wrap_i   (wrap),
      .cnt_i    (cnt),
      .cyc_i    (cyc),
      .pwm_o    (pwm_o[i])
    );
  end

  logic irq_sel;
  assign irq_sel = wr_en && (wr_addr == ADDR_W'(NCH));

  pwm_quad_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (irq_sel),
    .en_i   (wr_data[0]),
    .sup_i  (sup_e'(wr_data[2:1])),
    .wrap_i (wrap),
    .cyc_i  (cyc),
    .irq_o  (irq_o)
  );

endmodule

// File: tb/pwm_quad_bench.sv
module pwm_quad_bench;

  localparam int PER = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [12:0] wr_data = '0;
  logic [3:0]  pwm_o;
  logic        irq_o;

  always #10 clk = ~clk;

  pwm_quad u_pwm_quad (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pwm_o(pwm_o), .irq_o(irq_o)
  );

  int n_chk = 0, n_fail = 0;

  // Vector: {irq sup[15:14], irq en[13], ch0 sup[12:11], spread[10], duty[9:0]}
  localparam logic [15:0] VEC [0:6] = '{
    {2'd0, 1'b1, 2'd0, 1'b0, 10'd300},
    {2'd1, 1'b1, 2'd1, 1'b0, 10'd1023},
    {2'd0, 1'b0, 2'd0, 1'b1, 10'd515},
    {2'd2, 1'b1, 2'd2, 1'b1, 10'd2},
    {2'd3, 1'b1, 2'd0, 1'b1, 10'd0},
    {2'd0, 1'b1, 2'd3, 1'b0, 10'd1},
    {2'd0, 1'b0, 2'd3, 1'b1, 10'd1022}
  };

  // Bench model of the requirements
  int          m_cnt = 0, m_cyc = 0;
  logic [12:0] m_sh [0:4];
  logic [12:0] m_act [0:4];
  logic        m_irq = 1'b0;

  function automatic bit kept(int sup, int cyc);
    return (sup == 0) || ((cyc % (1 << sup)) == 0);
  endfunction

  function automatic bit exp_lvl(logic [12:0] cfg, int cnt, int cyc);
    int duty, q, p, w;
    duty = int'(cfg[9:0]);
    if (!kept(int'(cfg[12:11]), cyc)) return 1'b0;
    if (!cfg[10]) return cnt < duty;
    q = cnt / 256;
    p = cnt % 256;
    w = duty / 4 + (((duty % 4) > q) ? 1 : 0);
    return p < w;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt <= 0; m_cyc <= 0; m_irq <= 1'b0;
      for (int i = 0; i < 5; i++) begin m_sh[i] <= '0; m_act[i] <= '0; end
    end else begin
      if (wr_en && wr_addr < 3'd5) m_sh[wr_addr] <= wr_data;
      m_irq <= 1'b0;
      if (tick) begin
        if (m_cnt == PER - 1) begin
          m_cnt <= 0;
          m_cyc <= (m_cyc + 1) % 8;
          for (int i = 0; i < 5; i++) m_act[i] <= m_sh[i];
          m_irq <= m_act[4][0] && kept(int'(m_act[4][2:1]), m_cyc);
        end else m_cnt <= m_cnt + 1;
      end
    end
  end

  // Per-sample monitor
  bit mon_on = 1'b0;
  int hi [0:3];
  int mis [0:3];
  int irq_n = 0, mis_irq = 0;

  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      for (int c = 0; c < 4; c++) begin
        if (pwm_o[c] !== exp_lvl(m_act[c], m_cnt, m_cyc)) mis[c] = mis[c] + 1;
        if (pwm_o[c] === 1'b1) hi[c] = hi[c] + 1;
      end
      if (irq_o !== m_irq) mis_irq = mis_irq + 1;
      if (irq_o === 1'b1) irq_n = irq_n + 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [12:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cnt(input int v);
    do @(negedge clk); while (m_cnt != v);
  endtask

  // Wait until settings written so far are in force, at count 0.
  task automatic align();
    wait_cnt(PER - 1);
    wait_cnt(0);
  endtask

  // Count from the sample at count 1 for n samples.
  task automatic window(input int n);
    @(posedge clk);
    for (int c = 0; c < 4; c++) begin hi[c] = 0; mis[c] = 0; end
    irq_n = 0; mis_irq = 0;
    repeat (n) @(negedge clk);
    #1;
  endtask

  // Watchdog
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd == 190000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 4; c++) begin hi[c] = 0; mis[c] = 0; end
    repeat (4) @(negedge clk);
    // R9: outputs low during reset
    chk("R9 pwm in reset", int'(pwm_o), 0);
    chk("R9 irq in reset", int'(irq_o), 0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    wait_cnt(0);
    window(PER);
    // R9: nothing written yet, all channels low
    chk("R9 first period highs", hi[0] + hi[1] + hi[2] + hi[3], 0);
    chk("R9 first period mismatches", mis[0] + mis[1] + mis[2] + mis[3] + mis_irq, 0);

    // Fixed settings on channels 1..3 (R8 map: {sup, spread, duty})
    wr(1, {2'd0, 1'b0, 10'd0});
    wr(2, {2'd0, 1'b1, 10'd700});
    wr(3, {2'd1, 1'b1, 10'd1023});

    for (int v = 0; v < 7; v++) begin
      logic [15:0] e;
      int duty, sup, isup, exp_irq;
      e = VEC[v];
      duty = int'(e[9:0]); sup = int'(e[12:11]); isup = int'(e[15:14]);
      exp_irq = e[13] ? (8 >> isup) : 0;
      wr(0, e[12:0]);
      wr(4, {10'd0, e[15:14], e[13]});
      align();
      window(8 * PER);
      // R2 R3 R5: total high time over eight periods
      chk(e[10] ? "R3 R5 ch0 highs spread" : "R2 R5 ch0 highs single", hi[0], duty * (8 >> sup));
      // R2 R3: per-sample shape
      chk("R2 R3 R5 per-sample mismatches", mis[0] + mis[1] + mis[2] + mis[3], 0);
      // R6: interrupt count and timing
      chk("R6 irq pulses", irq_n, exp_irq);
      chk("R6 irq timing mismatches", mis_irq, 0);
      // R4 R3 R5: other channels
      chk("R4 ch1 duty 0", hi[1], 0);
      chk("R3 ch2 spread 700", hi[2], 700 * 8);
      chk("R5 ch3 1 of 2", hi[3], 1023 * 4);
    end

    // R7: mid-period write does not disturb the current period
    wr(0, {2'd0, 1'b0, 10'd600});
    align();
    wait_cnt(100);
    wr(0, {2'd0, 1'b0, 10'd50});
    wait_cnt(300);
    chk("R7 old duty still in force", int'(pwm_o[0]), 1);
    wait_cnt(0);
    wait_cnt(300);
    chk("R7 new duty at next period", int'(pwm_o[0]), 0);

    // R8: writes to unmapped addresses are ignored
    wr(4, 13'd1);
    align();
    wr(5, '1);
    wr(6, '1);
    wr(7, '1);
    align();
    window(8 * PER);
    chk("R8 ch0 unchanged", hi[0], 400);
    chk("R8 ch1 unchanged", hi[1], 0);
    chk("R8 ch2 unchanged", hi[2], 5600);
    chk("R8 ch3 unchanged", hi[3], 4092);
    chk("R8 irq unchanged", irq_n, 8);

    // R10: one channel written, others keep their output
    wr(2, {2'd0, 1'b0, 10'd100});
    align();
    window(8 * PER);
    chk("R10 ch2 new", hi[2], 800);
    chk("R10 ch0 kept", hi[0], 400);
    chk("R10 ch3 kept", hi[3], 4092);
    chk("R10 mismatches", mis[0] + mis[1] + mis[2] + mis[3], 0);

    // R1: stall on the last count, then mid-period
    begin
      logic [3:0] held;
      int changes;
      changes = 0;
      wait_cnt(PER - 1);
      tick = 1'b0;
      held = pwm_o;
      repeat (300) begin
        @(negedge clk);
        if (pwm_o !== held || irq_o !== 1'b0) changes++;
      end
      chk("R1 stall at last count", changes, 0);
      tick = 1'b1;
      wait_cnt(60);
      tick = 1'b0;
      held = pwm_o;
      changes = 0;
      repeat (200) begin
        @(negedge clk);
        if (pwm_o !== held) changes++;
      end
      chk("R1 stall mid period", changes, 0);
      tick = 1'b1;
      wait_cnt(0);
      window(PER);
      chk("R1 period after stall", mis[0] + mis[1] + mis[2] + mis[3] + mis_irq, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule